// File: doc/BRIEF.md
# Parallel Multi-Bit CRC Engine

This block computes a cyclic redundancy check over a data word of configurable width in one clock. The per-cycle next-state logic repeats the one-bit serial LFSR update once for every bit of the word, so a wide word costs only a deeper XOR network. The same source therefore serves widths from a single bit up to several hundred bits. The CRC width, generator polynomial, start value and word width are all parameters. The defaults give a 32-bit CRC with generator 0x04C11DB7, a start value of all ones and 8-bit words.

The engine keeps two state registers of CRC width. The first holds the direct (non-augmented) remainder. In that form each incoming bit is XORed with the register MSB, and the result decides whether the polynomial is applied after the shift. The second holds the classic augmented remainder. In that form the incoming bit enters at the LSB, and the polynomial is applied when the bit leaving the MSB is 1. A start pulse reloads both registers with the start value. Words are accepted while the valid input is high, and both registers hold their values otherwise. The outputs are the raw register contents, with no reflection and no final XOR.

Top module: `crc_par_engine`

## Requirements
- R1: When synchronous reset is high at a rising edge, both outputs equal the start value parameter after that edge.
- R2: On a cycle with valid high and start low, the direct output becomes the result of the direct-form update applied to its previous value. In that update, per bit, fb = msb XOR bit, the register shifts left with a 0 entering, and the polynomial is XORed in when fb is 1.
- R3: On a cycle with start high and valid low, both outputs equal the start value after the edge.
- R4: On a cycle with start and valid both low, both outputs keep their values whatever the data input carries.
- R5: When start and valid are high in the same cycle, start wins. The word is processed beginning from the start value rather than from the old state.
- R6: On a cycle with valid high, the augmented output is updated per bit as follows: the bit shifts into the LSB, and the polynomial is XORed in when the bit shifted out of the MSB was 1.
- R7: Within a word, bits are consumed from bit DATA_W-1 down to bit 0.
- R8: With the defaults, starting from 0xFFFFFFFF and feeding the bytes of ASCII "123456789" in order (0x31 first), the direct output ends at 0x0376E6E7.
- R9: The same source elaborates and computes correctly for word widths of 1, 8, 32 and 512 bits. A 1-bit engine fed the same message MSB-first within each byte reaches the same 0x0376E6E7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Reload both CRC registers with the start value |
| valid_i | input | 1 | Data word is consumed this cycle |
| data_i | input | DATA_W | Input word, MSB consumed first |
| crc_direct_o | output | CRC_W | Direct-form (non-augmented) CRC register |
| crc_aug_o | output | CRC_W | Augmented-form CRC register |

## Verification
Every result of this block appears exactly one rising edge after the cycle that presents it, because the only registers on the path are the two CRC state registers. This applies to a reset, a start pulse, a consumed word or an idle cycle. The bench changes inputs on the falling edge, lets one rising edge pass, and reads both outputs on the next falling edge. Its bit-serial reference models are advanced at that same point. The check value is read one cycle after the last byte (or the last bit, on the 1-bit engine) has been presented.

// File: rtl/crc_par_pkg.sv
package crc_par_pkg;

  localparam int unsigned CRC_MAX_W = 64;

  typedef logic [CRC_MAX_W-1:0] crc_word_t;

  // mask keeping the low w bits of a wide word
  function automatic crc_word_t crc_mask(input int unsigned w);
    crc_word_t m;
    if (w >= CRC_MAX_W) m = '1;
    else                m = (crc_word_t'(1) << w) - crc_word_t'(1);
    return m;
  endfunction

  // one serial step, direct form: feedback is msb xor incoming bit
  function automatic crc_word_t step_direct(input crc_word_t s, input logic b,
                                            input crc_word_t poly,
                                            input int unsigned w);
    logic      fb;
    crc_word_t m;
    m  = crc_mask(w);
    fb = s[w-1] ^ b;
    s  = (s << 1) & m;
    if (fb) s = s ^ (poly & m);
    return s;
  endfunction

  // one serial step, augmented form: bit enters at lsb, msb leaving decides
  function automatic crc_word_t step_aug(input crc_word_t s, input logic b,
                                         input crc_word_t poly,
                                         input int unsigned w);
    logic      out_bit;
    crc_word_t m;
    m       = crc_mask(w);
    out_bit = s[w-1];
    s       = ((s << 1) | crc_word_t'(b)) & m;
    if (out_bit) s = s ^ (poly & m);
    return s;
  endfunction

endpackage

// File: rtl/crc_lane.sv
module crc_lane
  import crc_par_pkg::*;
#(
  parameter int unsigned           CRC_W   = 32,
  parameter int unsigned           DATA_W  = 8,
  parameter logic [CRC_W-1:0]      POLY    = 32'h04C11DB7,
  parameter bit                    AUG     = 1'b0
) (
  input  logic [CRC_W-1:0]  seed_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  next_o
);

  // chain[k] is the state after k bits of the word
  logic [CRC_W-1:0] chain [0:DATA_W];

  assign chain[0] = seed_i;

  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    if (AUG) begin : g_aug
      assign chain[k+1] = CRC_W'(step_aug(crc_word_t'(chain[k]),
                                          data_i[DATA_W-1-k],
                                          crc_word_t'(POLY), CRC_W));
    end else begin : g_dir
      assign chain[k+1] = CRC_W'(step_direct(crc_word_t'(chain[k]),
                                             data_i[DATA_W-1-k],
                                             crc_word_t'(POLY), CRC_W));
    end
  end

  assign next_o = chain[DATA_W];

endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg #(
  parameter int unsigned      CRC_W = 32,
  parameter logic [CRC_W-1:0] SEED  = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [CRC_W-1:0] next_i,
  output logic [CRC_W-1:0] state_o
);

  always_ff @(posedge clk) begin
    if (rst)         state_o <= SEED;
    else if (adv_i)  state_o <= next_i;
    else if (load_i) state_o <= SEED;
  end

endmodule

// File: rtl/crc_par_engine.sv
module crc_par_engine #(
  parameter int unsigned      CRC_W  = 32,
  parameter int unsigned      DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY   = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] SEED   = 32'hFFFFFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_direct_o,
  output logic [CRC_W-1:0]  crc_aug_o
);

  // named internal events for the checker
  logic             ev_reload;
  logic             ev_consume;
  logic             ev_idle;
  logic [CRC_W-1:0] seed_direct;
  logic [CRC_W-1:0] seed_aug;
  logic [CRC_W-1:0] next_direct;
  logic [CRC_W-1:0] next_aug;

  assign ev_consume = valid_i;
  assign ev_reload  = start_i;
  assign ev_idle    = !start_i && !valid_i;

  // start has priority: a word arriving with start begins from the seed
  assign seed_direct = ev_reload ? SEED : crc_direct_o;
  assign seed_aug    = ev_reload ? SEED : crc_aug_o;

  crc_lane #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY), .AUG(1'b0)) u_lane_dir (
    .seed_i (seed_direct),
    .data_i (data_i),
    .next_o (next_direct)
  );

  crc_lane #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY), .AUG(1'b1)) u_lane_aug (
    .seed_i (seed_aug),
    .data_i (data_i),
    .next_o (next_aug)
  );

  crc_state_reg #(.CRC_W(CRC_W), .SEED(SEED)) u_reg_dir (
    .clk     (clk),
    .rst     (rst),
    .load_i  (ev_reload),
    .adv_i   (ev_consume),
    .next_i  (next_direct),
    .state_o (crc_direct_o)
  );

  crc_state_reg #(.CRC_W(CRC_W), .SEED(SEED)) u_reg_aug (
    .clk     (clk),
    .rst     (rst),
    .load_i  (ev_reload),
    .adv_i   (ev_consume),
    .next_i  (next_aug),
    .state_o (crc_aug_o)
  );

endmodule

// File: rtl/crc_par_engine_chk.sv
module crc_par_engine_chk #(
  parameter int unsigned      CRC_W  = 32,
  parameter int unsigned      DATA_W = 8,
  parameter logic [CRC_W-1:0] SEED   = 32'hFFFFFFFF
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              valid_i,
  input logic [DATA_W-1:0] data_i,
  input logic              ev_idle,
  input logic [CRC_W-1:0]  next_direct,
  input logic [CRC_W-1:0]  next_aug,
  input logic [CRC_W-1:0]  crc_direct_o,
  input logic [CRC_W-1:0]  crc_aug_o
);

  // R4: idle cycles keep both registers
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ev_idle |=> ($stable(crc_direct_o) && $stable(crc_aug_o)));

  // R3: a bare start pulse reloads the seed
  p_start_load_r3: assert property (@(posedge clk) disable iff (rst)
    (start_i && !valid_i) |=> (crc_direct_o == SEED && crc_aug_o == SEED));

  // R2: a consumed word lands the direct lane result in the register
  p_direct_capture_r2: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> (crc_direct_o == $past(next_direct)));

  // R6: a consumed word lands the augmented lane result in the register
  p_aug_capture_r6: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> (crc_aug_o == $past(next_aug)));

  // R2: zero state fed zero data stays zero (linearity of the direct form)
  p_zero_fixed_r2: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !start_i && data_i == '0 && crc_direct_o == '0)
      |=> (crc_direct_o == '0));

endmodule

bind crc_par_engine crc_par_engine_chk #(
  .CRC_W (CRC_W),
  .DATA_W(DATA_W),
  .SEED  (SEED)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .valid_i      (valid_i),
  .data_i       (data_i),
  .ev_idle      (ev_idle),
  .next_direct  (next_direct),
  .next_aug     (next_aug),
  .crc_direct_o (crc_direct_o),
  .crc_aug_o    (crc_aug_o)
);

// File: tb/crc_par_engine_test.sv
module crc_par_engine_test;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] GEN        = 32'h04C11DB7;
  localparam logic [31:0] START_VAL  = 32'hFFFFFFFF;
  localparam logic [31:0] CHECK_VAL  = 32'h0376E6E7;

  // {start, valid, byte} for the check-value message
  localparam logic [9:0] VEC [9] = '{
    {2'b11, 8'h31}, {2'b01, 8'h32}, {2'b01, 8'h33},
    {2'b01, 8'h34}, {2'b01, 8'h35}, {2'b01, 8'h36},
    {2'b01, 8'h37}, {2'b01, 8'h38}, {2'b01, 8'h39}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         st  = 1'b0;
  logic         vl  = 1'b0;
  logic [511:0] dw  = '0;

  logic [31:0] d1_o, a1_o, d8_o, a8_o, d32_o, a32_o, d512_o, a512_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] md [4];
  logic [31:0] ma [4];
  localparam int WIDTHS [4] = '{1, 8, 32, 512};

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_par_engine #(.DATA_W(1)) u_w1 (
    .clk(clk), .rst(rst), .start_i(st), .valid_i(vl), .data_i(dw[0]),
    .crc_direct_o(d1_o), .crc_aug_o(a1_o));
  crc_par_engine #(.DATA_W(8)) uut (
    .clk(clk), .rst(rst), .start_i(st), .valid_i(vl), .data_i(dw[7:0]),
    .crc_direct_o(d8_o), .crc_aug_o(a8_o));
  crc_par_engine #(.DATA_W(32)) u_w32 (
    .clk(clk), .rst(rst), .start_i(st), .valid_i(vl), .data_i(dw[31:0]),
    .crc_direct_o(d32_o), .crc_aug_o(a32_o));
  crc_par_engine #(.DATA_W(512)) u_w512 (
    .clk(clk), .rst(rst), .start_i(st), .valid_i(vl), .data_i(dw),
    .crc_direct_o(d512_o), .crc_aug_o(a512_o));

  // bit-serial reference, direct form, MSB first
  function automatic logic [31:0] ref_dir(logic [31:0] s, logic [511:0] d, int n);
    for (int k = n - 1; k >= 0; k--) begin
      logic top;
      top = s[31] ^ d[k];
      s   = {s[30:0], 1'b0};
      if (top) s = s ^ GEN;
    end
    return s;
  endfunction

  // bit-serial reference, augmented form, MSB first
  function automatic logic [31:0] ref_aug(logic [31:0] s, logic [511:0] d, int n);
    for (int k = n - 1; k >= 0; k--) begin
      logic [32:0] wide;
      wide = {s, d[k]};
      s    = wide[31:0];
      if (wide[32]) s = s ^ GEN;
    end
    return s;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " w1 direct"},   d1_o,   md[0]);
    check({tag, " w1 aug"},      a1_o,   ma[0]);
    check({tag, " w8 direct"},   d8_o,   md[1]);
    check({tag, " w8 aug"},      a8_o,   ma[1]);
    check({tag, " w32 direct"},  d32_o,  md[2]);
    check({tag, " w32 aug"},     a32_o,  ma[2]);
    check({tag, " w512 direct"}, d512_o, md[3]);
    check({tag, " w512 aug"},    a512_o, ma[3]);
  endtask

  // present one cycle at a falling edge, check after the next rising edge
  task automatic step(bit s_in, bit v_in, logic [511:0] d, string tag, bit chk);
    st = s_in; vl = v_in; dw = d;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] bd, ba;
      bd = s_in ? START_VAL : md[i];
      ba = s_in ? START_VAL : ma[i];
      if (v_in) begin
        md[i] = ref_dir(bd, d, WIDTHS[i]);
        ma[i] = ref_aug(ba, d, WIDTHS[i]);
      end else begin
        md[i] = bd;
        ma[i] = ba;
      end
    end
    @(posedge clk);
    @(negedge clk);
    if (chk) check_all(tag);
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin md[i] = START_VAL; ma[i] = START_VAL; end

    // R1: reset state
    @(negedge clk);
    st = 1'b1; vl = 1'b1; dw = rnd512();
    @(posedge clk);
    @(negedge clk);
    check_all("R1 reset");
    rst = 1'b0;

    // R8: table of the check-value message on the 8-bit engine
    for (int i = 0; i < 9; i++) begin
      logic [511:0] d;
      d = '0; d[7:0] = VEC[i][7:0];
      step(VEC[i][9], VEC[i][8], d, "R8 message", 1'b0);
    end
    check("R8 check value w8", d8_o, CHECK_VAL);
    check("R8 model agrees", md[1], CHECK_VAL);

    // R9 R7: same message bit by bit on the 1-bit engine, MSB first per byte
    step(1'b1, 1'b0, '0, "R9 start", 1'b0);
    for (int i = 0; i < 9; i++) begin
      for (int b = 7; b >= 0; b--) begin
        logic [511:0] d;
        d = '0; d[0] = VEC[i][b];
        step(1'b0, 1'b1, d, "R9 serial", 1'b0);
      end
    end
    check("R9 R7 check value w1", d1_o, CHECK_VAL);

    // R7: ordering sensitivity, single set bit at top versus bottom
    step(1'b1, 1'b1, 512'h80, "R7 top bit", 1'b1);
    step(1'b1, 1'b1, 512'h01, "R7 bottom bit", 1'b1);

    // R2 R6 R9: random words at every width
    step(1'b1, 1'b0, '0, "R3 start only", 1'b1);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, rnd512(), "R2 R6 R9 random", 1'b1);

    // R4: idle with toggling data
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, rnd512(), "R4 idle hold", 1'b1);

    // R5: start together with valid
    step(1'b1, 1'b1, rnd512(), "R5 start with data", 1'b1);
    step(1'b0, 1'b1, rnd512(), "R2 after R5", 1'b1);

    // R3: start only after activity
    step(1'b1, 1'b0, rnd512(), "R3 reload", 1'b1);

    // R2: all-zero and all-one words
    step(1'b0, 1'b1, '0, "R2 zero word", 1'b1);
    step(1'b0, 1'b1, '1, "R2 ones word", 1'b1);

    // R1: reset mid-stream
    rst = 1'b1;
    for (int i = 0; i < 4; i++) begin md[i] = START_VAL; ma[i] = START_VAL; end
    st = 1'b0; vl = 1'b1; dw = rnd512();
    @(posedge clk);
    @(negedge clk);
    check_all("R1 reset mid-stream");
    rst = 1'b0;
    vl = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule